// File: doc/BRIEF.md
# Dual Handshaked Parallel Port

This block gives a processor two byte-wide parallel ports, A and B, to talk to external peripherals. Each port has a data pin group with separate input, output and output-enable signals, plus one ready output and one active-low strobe input that together carry a handshake with the peripheral. Software sets each port to one of four operating modes through a small register interface. It writes output bytes, reads input bytes, and polls a status word.

The four modes are as follows:
- **Output (0):** the port presents a byte and waits for the peripheral to take it.
- **Input (1):** the port waits for the peripheral to strobe a byte in.
- **Bidirectional (2):** allowed on port A only. Port A carries traffic in both directions. Port A's own handshake pair serves the outgoing side, and port B's pair serves the incoming side.
- **Bit control (3):** each pin is independently an input or an output and there is no handshake.

While port A is bidirectional, port B is held in bit-control mode. Strobes are brought into the clock domain by a two-stage synchronizer. A transfer completes when the synchronized strobe rises.

Top module: `pport_pair`

## Requirements
- R1: After reset both ports are in mode 3 with a zero direction mask, zero data registers, both ready outputs low and all output enables low.
- R2: Address bits [3:2] pick the port (0 = A, 1 = B, others read 0). Bits [1:0] pick the register: 0 data, 1 mode (bits [1:0]), 2 direction mask (1 = output pin), 3 status (bit0 main ready, bit1 input-side ready of the bidirectional mode, bit2 transfer done). Read data appears on the clock edge that samples the read.
- R3: In mode 0 a data write drives the byte on the pins with all enables high and raises ready.
- R4: In mode 0 a strobe rising edge while ready is high drops ready and sets the sticky done bit. A status read returns done and then clears it.
- R5: Entering mode 1 raises ready. While ready is high and the strobe is low, the pins are copied into the input register. The strobe rising edge drops ready.
- R6: In mode 1, strobes arriving while ready is low leave the input register unchanged. A data read raises ready again.
- R7: In mode 3 the output enables equal the mask and ready is low. A data read returns the sampled pin for mask-0 bits and the output register for mask-1 bits. Strobes change nothing.
- R8: A write of mode 2 to port B is ignored and its mode stays as it was.
- R9: While port A is in mode 2, port B switches to mode 3 and ignores writes to its mode register.
- R10: In mode 2 an A data write raises A-ready. The A pins are enabled only while the A strobe is low. The A strobe rising edge drops A-ready and sets done.
- R11: In mode 2 B-ready means port A can accept input. A low B strobe copies the A pins into A's input register, and its rising edge drops B-ready. An A data read raises B-ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| a_pin_in | input | 8 | Port A pin input values |
| a_pin_out | output | 8 | Port A pin output values |
| a_pin_oe | output | 8 | Port A per-pin output enable |
| a_rdy | output | 1 | Port A ready |
| a_stb_n | input | 1 | Port A strobe, active low |
| b_pin_in | input | 8 | Port B pin input values |
| b_pin_out | output | 8 | Port B pin output values |
| b_pin_oe | output | 8 | Port B per-pin output enable |
| b_rdy | output | 1 | Port B ready, or port A input-ready in mode 2 |
| b_stb_n | input | 1 | Port B strobe, active low |

## Verification
The assertions check on every cycle the rules that hold on every cycle:
- port B never holds mode 2;
- port B sits in mode 3 while port A is bidirectional;
- bit-control ports keep ready low;
- input-mode ports drive no pins;
- output pins hold still unless a data write arrives.

The handshake sequences can only be shown by the bench's scenarios. These include ready rising on a write and falling on a strobe edge, input capture, strobes ignored while a byte waits unread, done clearing on a status read, the mixed read in bit-control mode, and port A borrowing port B's handshake lines.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    PM_OUT    = 2'd0,
    PM_IN     = 2'd1,
    PM_BIDIR  = 2'd2,
    PM_BITCTL = 2'd3
  } pmode_t;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_MASK = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
endpackage

// File: rtl/pport_sync.sv
module pport_sync (
  input  logic clk,
  input  logic rst,
  input  logic stb_n,
  output logic lo,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= 3'b111;
    else     sh <= {sh[1:0], stb_n};
  end

  assign lo   = ~sh[1];
  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/pport_chan.sv
module pport_chan
  import pport_pkg::*;
#(
  parameter int DW          = 8,
  parameter bit ALLOW_BIDIR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic          force_bitctl,
  input  logic          main_lo,
  input  logic          main_rise,
  input  logic          aux_lo,
  input  logic          aux_rise,
  input  logic [DW-1:0] pin_in,
  output pmode_t        mode,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic          rdy_main,
  output logic          rdy_aux
);
  logic [DW-1:0] out_q, in_q, mask_q, pin_q;
  logic          done_q;
  logic          mode_wr, data_wr, mask_wr, data_rd, stat_rd, mode_ok;
  pmode_t        new_mode;

  assign mode_wr  = wr_en && reg_sel == REG_MODE;
  assign data_wr  = wr_en && reg_sel == REG_DATA;
  assign mask_wr  = wr_en && reg_sel == REG_MASK;
  assign data_rd  = rd_en && reg_sel == REG_DATA;
  assign stat_rd  = rd_en && reg_sel == REG_STAT;
  assign new_mode = pmode_t'(wdata[1:0]);
  assign mode_ok  = ALLOW_BIDIR || (new_mode != PM_BIDIR);
  assign pin_out  = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= PM_BITCTL;
      out_q    <= '0;
      in_q     <= '0;
      mask_q   <= '0;
      pin_q    <= '0;
      pin_oe   <= '0;
      done_q   <= 1'b0;
      rdy_main <= 1'b0;
      rdy_aux  <= 1'b0;
    end else begin
      pin_q <= pin_in;
      case (mode)
        PM_OUT:   pin_oe <= '1;
        PM_IN:    pin_oe <= '0;
        PM_BIDIR: pin_oe <= main_lo ? '1 : '0;
        default:  pin_oe <= mask_q;
      endcase
      if (data_wr) out_q  <= wdata;
      if (mask_wr) mask_q <= wdata;

      if (force_bitctl && mode != PM_BITCTL) begin
        mode     <= PM_BITCTL;
        rdy_main <= 1'b0;
        rdy_aux  <= 1'b0;
      end else if (mode_wr && !force_bitctl && mode_ok) begin
        mode     <= new_mode;
        done_q   <= 1'b0;
        rdy_main <= (new_mode == PM_IN);
        rdy_aux  <= (new_mode == PM_BIDIR);
      end else begin
        if (stat_rd) done_q <= 1'b0;
        case (mode)
          PM_OUT: begin
            if (main_rise && rdy_main) begin
              rdy_main <= 1'b0;
              done_q   <= 1'b1;
            end
            if (data_wr) rdy_main <= 1'b1;
          end
          PM_IN: begin
            if (main_lo && rdy_main)   in_q     <= pin_in;
            if (main_rise && rdy_main) rdy_main <= 1'b0;
            if (data_rd && !rdy_main)  rdy_main <= 1'b1;
          end
          PM_BIDIR: begin
            if (main_rise && rdy_main) begin
              rdy_main <= 1'b0;
              done_q   <= 1'b1;
            end
            if (data_wr) rdy_main <= 1'b1;
            if (aux_lo && rdy_aux)   in_q    <= pin_in;
            if (aux_rise && rdy_aux) rdy_aux <= 1'b0;
            if (data_rd && !rdy_aux) rdy_aux <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_sel)
      REG_DATA: begin
        if (mode == PM_OUT)         rd_val = out_q;
        else if (mode == PM_BITCTL) rd_val = (pin_q & ~mask_q) | (out_q & mask_q);
        else                        rd_val = in_q;
      end
      REG_MODE: rd_val[1:0] = mode;
      REG_MASK: rd_val = mask_q;
      default:  rd_val[2:0] = {done_q, rdy_aux, rdy_main};
    endcase
  end
endmodule

// File: rtl/pport_pair.sv
module pport_pair
  import pport_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] a_pin_in,
  output logic [DW-1:0] a_pin_out,
  output logic [DW-1:0] a_pin_oe,
  output logic          a_rdy,
  input  logic          a_stb_n,
  input  logic [DW-1:0] b_pin_in,
  output logic [DW-1:0] b_pin_out,
  output logic [DW-1:0] b_pin_oe,
  output logic          b_rdy,
  input  logic          b_stb_n
);
  localparam int NPORT = 2;
  localparam int SW    = AW - 2;

  logic [SW-1:0]    port_sel;
  logic [1:0]       reg_sel;
  logic [NPORT-1:0] stb_vec, lo_vec, rise_vec, hit;
  logic [DW-1:0]    a_rd, b_rd;
  logic             a_aux, b_main, b_aux;
  pmode_t           a_mode, b_mode;

  assign port_sel = cpu_addr[AW-1:2];
  assign reg_sel  = cpu_addr[1:0];
  assign stb_vec  = {b_stb_n, a_stb_n};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign hit[g] = (port_sel == SW'(g));
    pport_sync u_sync (
      .clk(clk), .rst(rst), .stb_n(stb_vec[g]),
      .lo(lo_vec[g]), .rise(rise_vec[g])
    );
  end

  pport_chan #(.DW(DW), .ALLOW_BIDIR(1'b1)) u_chan_a (
    .clk(clk), .rst(rst), .reg_sel(reg_sel),
    .wr_en(cpu_wr && hit[0]), .rd_en(cpu_rd && hit[0]), .wdata(cpu_wdata),
    .force_bitctl(1'b0),
    .main_lo(lo_vec[0]), .main_rise(rise_vec[0]),
    .aux_lo(lo_vec[1]), .aux_rise(rise_vec[1]),
    .pin_in(a_pin_in), .mode(a_mode), .rd_val(a_rd),
    .pin_out(a_pin_out), .pin_oe(a_pin_oe),
    .rdy_main(a_rdy), .rdy_aux(a_aux)
  );

  pport_chan #(.DW(DW), .ALLOW_BIDIR(1'b0)) u_chan_b (
    .clk(clk), .rst(rst), .reg_sel(reg_sel),
    .wr_en(cpu_wr && hit[1]), .rd_en(cpu_rd && hit[1]), .wdata(cpu_wdata),
    .force_bitctl(a_mode == PM_BIDIR),
    .main_lo(lo_vec[1]), .main_rise(rise_vec[1]),
    .aux_lo(1'b0), .aux_rise(1'b0),
    .pin_in(b_pin_in), .mode(b_mode), .rd_val(b_rd),
    .pin_out(b_pin_out), .pin_oe(b_pin_oe),
    .rdy_main(b_main), .rdy_aux(b_aux)
  );

  assign b_rdy = (a_mode == PM_BIDIR) ? a_aux : (b_main | b_aux);

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_rd) begin
      if (hit[0])      cpu_rdata <= a_rd;
      else if (hit[1]) cpu_rdata <= b_rd;
      else             cpu_rdata <= '0;
    end
  end
endmodule

// File: rtl/pport_pair_chk.sv
module pport_pair_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    a_mode,
  input logic [1:0]    b_mode,
  input logic          a_rdy,
  input logic          b_rdy,
  input logic [DW-1:0] a_pin_oe,
  input logic [DW-1:0] a_pin_out,
  input logic          cpu_wr,
  input logic [AW-1:0] cpu_addr
);
  AST_B_NEVER_BIDIR: assert property (@(posedge clk) disable iff (rst)
    b_mode != 2'd2); // R8

  AST_BIDIR_PINS_B: assert property (@(posedge clk) disable iff (rst)
    (a_mode == 2'd2 && $past(a_mode) == 2'd2) |-> b_mode == 2'd3); // R9

  AST_BITCTL_RDY_LOW: assert property (@(posedge clk) disable iff (rst)
    (a_mode == 2'd3) |-> !a_rdy); // R7

  AST_BITCTL_RDY_LOW_B: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 2'd3 && a_mode != 2'd2) |-> !b_rdy); // R7

  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (a_mode == 2'd1 && $past(a_mode) == 2'd1) |-> a_pin_oe == '0); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(a_mode) == 2'd0 && !$past(cpu_wr && cpu_addr == '0)) |-> $stable(a_pin_out)); // R3
endmodule

bind pport_pair pport_pair_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .a_mode(a_mode), .b_mode(b_mode),
  .a_rdy(a_rdy), .b_rdy(b_rdy), .a_pin_oe(a_pin_oe), .a_pin_out(a_pin_out),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr)
);

// File: tb/pport_pair_tb.sv
module pport_pair_tb;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic [DW-1:0] a_pin_in = '0, a_pin_out, a_pin_oe;
  logic [DW-1:0] b_pin_in = '0, b_pin_out, b_pin_oe;
  logic          a_rdy, b_rdy;
  logic          a_stb_n = 1'b1, b_stb_n = 1'b1;

  int errors = 0;
  int checks = 0;
  logic rd_q = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pport_pair #(.DW(DW), .AW(AW)) u_dut (.*);

  always @(posedge clk) rd_q <= cpu_rd;

  // monitor: pops one expected item per read result
  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: act=%h exp=none", cpu_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (cpu_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: act=%h exp=%h", it.tag, cpu_rdata, it.exp);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pulse_a(input int n);
    @(negedge clk); a_stb_n = 1'b0;
    repeat (n) @(negedge clk);
    a_stb_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_b(input int n);
    @(negedge clk); b_stb_n = 1'b0;
    repeat (n) @(negedge clk);
    b_stb_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 a_rdy", {7'd0, a_rdy}, 8'h00);
    check("R1 b_rdy", {7'd0, b_rdy}, 8'h00);
    check("R1 a_oe", a_pin_oe, 8'h00);
    rd(4'h1, 8'h03, "R1 A mode");
    rd(4'h6, 8'h00, "R1 B mask");
    rd(4'hC, 8'h00, "R2 unmapped");

    // R3/R4 output mode on A
    wr(4'h1, 8'h00);
    wr(4'h0, 8'h5A);
    settle();
    check("R3 a_rdy", {7'd0, a_rdy}, 8'h01);
    check("R3 a_pin_out", a_pin_out, 8'h5A);
    check("R3 a_oe", a_pin_oe, 8'hFF);
    pulse_a(3);
    check("R4 a_rdy drop", {7'd0, a_rdy}, 8'h00);
    rd(4'h3, 8'h04, "R4 done set");
    rd(4'h3, 8'h00, "R4 done cleared");

    // R5/R6 input mode on B
    wr(4'h5, 8'h01);
    settle();
    check("R5 b_rdy", {7'd0, b_rdy}, 8'h01);
    check("R5 b_oe", b_pin_oe, 8'h00);
    b_pin_in = 8'h3C;
    pulse_b(3);
    check("R5 b_rdy drop", {7'd0, b_rdy}, 8'h00);
    b_pin_in = 8'h99;
    pulse_b(3);
    rd(4'h4, 8'h3C, "R6 ignored strobe");
    settle();
    check("R6 b_rdy after read", {7'd0, b_rdy}, 8'h01);

    // R8 bidirectional refused on B
    wr(4'h5, 8'h02);
    rd(4'h5, 8'h01, "R8 B mode kept");

    // R7 bit control on B
    wr(4'h5, 8'h03);
    wr(4'h6, 8'hF0);
    wr(4'h4, 8'hA5);
    b_pin_in = 8'h0F;
    settle();
    check("R7 b_oe", b_pin_oe, 8'hF0);
    check("R7 b_pin_out", b_pin_out, 8'hA5);
    rd(4'h4, 8'hAF, "R7 mixed read");
    pulse_b(3);
    check("R7 b_rdy low", {7'd0, b_rdy}, 8'h00);
    rd(4'h7, 8'h00, "R7 status untouched");

    // R9 A bidirectional forces B
    wr(4'h5, 8'h01);
    wr(4'h1, 8'h02);
    settle();
    rd(4'h5, 8'h03, "R9 B forced");
    wr(4'h5, 8'h01);
    rd(4'h5, 8'h03, "R9 B write ignored");
    check("R11 b_rdy accept", {7'd0, b_rdy}, 8'h01);
    check("R10 a_rdy idle", {7'd0, a_rdy}, 8'h00);

    // R10 output side of bidirectional mode
    wr(4'h0, 8'hC3);
    settle();
    check("R10 a_rdy", {7'd0, a_rdy}, 8'h01);
    check("R10 oe off", a_pin_oe, 8'h00);
    @(negedge clk); a_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 oe on", a_pin_oe, 8'hFF);
    check("R10 pins", a_pin_out, 8'hC3);
    a_stb_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 oe off again", a_pin_oe, 8'h00);
    check("R10 a_rdy drop", {7'd0, a_rdy}, 8'h00);
    rd(4'h3, 8'h06, "R10 status");

    // R11 input side of bidirectional mode
    a_pin_in = 8'h77;
    pulse_b(3);
    check("R11 b_rdy drop", {7'd0, b_rdy}, 8'h00);
    rd(4'h0, 8'h77, "R11 captured");
    settle();
    check("R11 b_rdy back", {7'd0, b_rdy}, 8'h01);

    settle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule